// File: doc/BRIEF.md
# Half-Operand SIMD Arithmetic/Logic Unit

This block is a purely combinational 128-bit SIMD arithmetic/logic unit. The field width is picked per operation as a power of two from 2 to 128 bits. The vector is split into equal fields, and one vertical operation is applied to each field independently. The operations are wrapping add, wrapping subtract, unsigned minimum, bitwise OR, AND and XOR, per-field rotate-left, and a bitwise mask select.

Each of the two data operands first passes through a half-field modifier. The modifier can keep the field as it is, move the upper half of every field down into the lower half, or keep only the lower half of every field. Suppose both operands come from the same register, one modifier takes high halves and the other takes low halves. The vertical operation then combines every pair of adjacent half-width fields into one full-width result. This gives horizontal pairwise reductions with no dedicated horizontal logic.

A rotate left by n−i inside an n-bit field is the same as a rotate right by i. Software can therefore right-justify fields with the rotate operation.

Top module: `simd_hmod_alu`

## Requirements
- R1: `width_log2` codes 1 to 7 select a field width of 2^code bits (2 to 128), and `out_valid` is 1 for these codes.
- R2: `width_log2` code 0 drives `out_valid` to 0 and `result` to all zeros, whatever the other inputs are.
- R3: Modifier code 0 passes each field unchanged. Code 1 shifts the upper n/2 bits of each field down into the lower half and zero-fills the upper half. Code 2 zeroes the upper n/2 bits of each field. Code 3 behaves like code 0. `mod_a` applies to `src_a` and `mod_b` applies to `src_b`. The select mask is never modified.
- R4: Opcode 0 gives, per field, the sum of the modified operands modulo 2^n. No carry crosses a field boundary.
- R5: Opcode 1 gives, per field, modified A minus modified B, modulo 2^n.
- R6: Opcode 2 gives, per field, the unsigned minimum of the modified operands.
- R7: Opcodes 3, 4 and 5 give the bitwise OR, AND and XOR of the modified operands at every field width.
- R8: Opcode 6 rotates each modified A field left by the value in the low log2(n) bits of the matching modified B field.
- R9: Opcode 7 takes each result bit from modified A where the `sel_mask` bit is 1, and from modified B where it is 0.
- R10: Add at 16-bit width, with both operands equal, A high and B low, yields the full 16-bit sum of every pair of adjacent bytes.
- R11: Unsigned minimum at 32-bit width, with both operands equal, A high and B low, yields the smaller value of every pair of adjacent 16-bit fields.
- R12: A rotate left by n−i inside an n-bit field equals a rotate right by i. A field whose low i bits are zero comes out right-justified by i positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 128 | First data operand |
| src_b | input | 128 | Second data operand (also rotate amounts) |
| sel_mask | input | 128 | Bit mask for the select operation |
| op_code | input | 3 | Operation: 0 add, 1 sub, 2 min, 3 or, 4 and, 5 xor, 6 rotl, 7 select |
| width_log2 | input | 3 | log2 of the field width; 0 is invalid |
| mod_a | input | 2 | Half-field modifier for `src_a` |
| mod_b | input | 2 | Half-field modifier for `src_b` |
| result | output | 128 | Per-field result |
| out_valid | output | 1 | High when the width code is legal |

## Verification
The embedded checks assume that every input has a known value in the cycle they are evaluated. They also rely on the opcode and modifier values all being defined encodings. The bench meets both assumptions by driving every input at each step, never leaving a port floating. It sweeps every opcode, every modifier pair and every width code, including the illegal code 0. The select property checks only the case where both modifiers pass fields through unchanged, because only there do the raw operands equal the values being chosen between. Random operands cover the arithmetic corners statistically. Directed vectors pin down the horizontal add and minimum, the carry out of each byte pair, and the right-justification identity.

// File: rtl/simd_hmod_pkg.sv
package simd_hmod_pkg;

   // Vertical per-field operations
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_MINU = 3'd2,
      OP_OR   = 3'd3,
      OP_AND  = 3'd4,
      OP_XOR  = 3'd5,
      OP_ROTL = 3'd6,
      OP_SEL  = 3'd7
   } simd_op_e;

   // Half-field operand modifiers
   typedef enum logic [1:0] {
      HM_FULL = 2'd0,
      HM_HIGH = 2'd1,
      HM_LOW  = 2'd2,
      HM_ALT  = 2'd3
   } half_mod_e;

endpackage

// File: rtl/simd_half_mod.sv
module simd_half_mod
   import simd_hmod_pkg::*;
#(
   parameter int DW     = 128,
   parameter int LOG_FW = 3
) (
   input  logic [DW-1:0] vec_in,
   input  half_mod_e     mode,
   output logic [DW-1:0] vec_out
);
   localparam int FW = 1 << LOG_FW;
   localparam int HW = FW / 2;
   localparam int NF = DW / FW;

   generate
      if (LOG_FW < 1) begin : g_bad_log
         $error("simd_half_mod: LOG_FW must be at least 1");
      end
      if (FW > DW) begin : g_bad_fw
         $error("simd_half_mod: field wider than vector");
      end
   endgenerate

   for (genvar f = 0; f < NF; f++) begin : g_field
      logic [FW-1:0] fin;
      logic [FW-1:0] fout;
      assign fin = vec_in[f*FW +: FW];
      always_comb begin
         unique case (mode)
            HM_HIGH: fout = {{HW{1'b0}}, fin[FW-1:HW]};
            HM_LOW:  fout = {{HW{1'b0}}, fin[HW-1:0]};
            default: fout = fin;
         endcase
      end
      assign vec_out[f*FW +: FW] = fout;
   end

endmodule

// File: rtl/simd_field_op.sv
module simd_field_op
   import simd_hmod_pkg::*;
#(
   parameter int FW = 8
) (
   input  logic [FW-1:0] fa,
   input  logic [FW-1:0] fb,
   input  logic [FW-1:0] fm,
   input  simd_op_e      op,
   output logic [FW-1:0] fres
);
   localparam int AW = (FW > 1) ? $clog2(FW) : 1;

   generate
      if (FW < 2) begin : g_bad_fw
         $error("simd_field_op: FW must be at least 2");
      end
      if ((FW & (FW - 1)) != 0) begin : g_bad_pow
         $error("simd_field_op: FW must be a power of two");
      end
   endgenerate

   logic [AW-1:0]   rot_amt;
   logic [2*FW-1:0] rot_dbl;
   logic [FW-1:0]   rot_val;

   assign rot_amt = fb[AW-1:0];
   assign rot_dbl = {fa, fa} << rot_amt;
   assign rot_val = rot_dbl[2*FW-1:FW];

   always_comb begin
      unique case (op)
         OP_ADD:  fres = fa + fb;
         OP_SUB:  fres = fa - fb;
         OP_MINU: fres = (fa < fb) ? fa : fb;
         OP_OR:   fres = fa | fb;
         OP_AND:  fres = fa & fb;
         OP_XOR:  fres = fa ^ fb;
         OP_ROTL: fres = rot_val;
         OP_SEL:  fres = (fa & fm) | (fb & ~fm);
         default: fres = '0;
      endcase
   end

   // Embedded checks relating the field result to its operands
   always_comb begin
      if (op == OP_ADD)
         AST_ADD_WRAP: assert (FW'(fres - fb) == fa) else $error("add wrap"); // R4
      if (op == OP_SUB)
         AST_SUB_WRAP: assert (FW'(fres + fb) == fa) else $error("sub wrap"); // R5
      if (op == OP_MINU)
         AST_MIN_BOUND: assert (fres <= fa && fres <= fb && (fres == fa || fres == fb)) else $error("min bound"); // R6
      if (op == OP_ROTL)
         AST_ROT_ONES: assert ($countones(fres) == $countones(fa)) else $error("rot ones"); // R8
   end

endmodule

// File: rtl/simd_width_lane.sv
module simd_width_lane
   import simd_hmod_pkg::*;
#(
   parameter int DW     = 128,
   parameter int LOG_FW = 3
) (
   input  logic [DW-1:0] src_a,
   input  logic [DW-1:0] src_b,
   input  logic [DW-1:0] sel_mask,
   input  simd_op_e      op,
   input  half_mod_e     mod_a,
   input  half_mod_e     mod_b,
   output logic [DW-1:0] lane_out
);
   localparam int FW = 1 << LOG_FW;
   localparam int NF = DW / FW;

   generate
      if (NF < 1) begin : g_bad_nf
         $error("simd_width_lane: no fields at this width");
      end
   endgenerate

   logic [DW-1:0] a_mod;
   logic [DW-1:0] b_mod;

   simd_half_mod #(.DW(DW), .LOG_FW(LOG_FW)) u_mod_a (
      .vec_in  (src_a),
      .mode    (mod_a),
      .vec_out (a_mod)
   );

   simd_half_mod #(.DW(DW), .LOG_FW(LOG_FW)) u_mod_b (
      .vec_in  (src_b),
      .mode    (mod_b),
      .vec_out (b_mod)
   );

   for (genvar f = 0; f < NF; f++) begin : g_fop
      simd_field_op #(.FW(FW)) u_fop (
         .fa   (a_mod[f*FW +: FW]),
         .fb   (b_mod[f*FW +: FW]),
         .fm   (sel_mask[f*FW +: FW]),
         .op   (op),
         .fres (lane_out[f*FW +: FW])
      );
   end

endmodule

// File: rtl/simd_hmod_alu.sv
module simd_hmod_alu
   import simd_hmod_pkg::*;
#(
   parameter int DW      = 128,
   parameter int MIN_LOG = 1,
   parameter int LW_W    = $clog2($clog2(DW) + 1)
) (
   input  logic [DW-1:0]   src_a,
   input  logic [DW-1:0]   src_b,
   input  logic [DW-1:0]   sel_mask,
   input  logic [2:0]      op_code,
   input  logic [LW_W-1:0] width_log2,
   input  logic [1:0]      mod_a,
   input  logic [1:0]      mod_b,
   output logic [DW-1:0]   result,
   output logic            out_valid
);
   localparam int MAX_LOG = $clog2(DW);
   localparam int NLANE   = MAX_LOG + 1;
   localparam logic [LW_W-1:0] MIN_CODE = LW_W'(MIN_LOG);
   localparam logic [LW_W-1:0] MAX_CODE = LW_W'(MAX_LOG);

   generate
      if ((DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("simd_hmod_alu: DW must be a power of two");
      end
      if (MIN_LOG < 1 || MIN_LOG > MAX_LOG) begin : g_bad_min
         $error("simd_hmod_alu: MIN_LOG out of range");
      end
      if ((1 << LW_W) < NLANE) begin : g_bad_lw
         $error("simd_hmod_alu: width code too narrow");
      end
   endgenerate

   simd_op_e  op_e;
   half_mod_e ma_e;
   half_mod_e mb_e;

   assign op_e = simd_op_e'(op_code);
   assign ma_e = half_mod_e'(mod_a);
   assign mb_e = half_mod_e'(mod_b);

   logic [DW-1:0] lane_res [NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      if (g >= MIN_LOG) begin : g_live
         simd_width_lane #(.DW(DW), .LOG_FW(g)) u_lane (
            .src_a    (src_a),
            .src_b    (src_b),
            .sel_mask (sel_mask),
            .op       (op_e),
            .mod_a    (ma_e),
            .mod_b    (mb_e),
            .lane_out (lane_res[g])
         );
      end else begin : g_dead
         assign lane_res[g] = '0;
      end
   end

   always_comb begin
      out_valid = (width_log2 >= MIN_CODE) && (width_log2 <= MAX_CODE);
      result    = out_valid ? lane_res[width_log2] : '0;
   end

   // Port-level checks
   always_comb begin
      if (width_log2 == '0)
         AST_BAD_CODE_ZERO: assert (!out_valid && result == '0) else $error("bad width code"); // R2
      if (out_valid && op_e == OP_SEL && ma_e == HM_FULL && mb_e == HM_FULL)
         AST_SEL_SOURCE: assert ((((result ^ src_a) & sel_mask) == '0) && (((result ^ src_b) & ~sel_mask) == '0)) else $error("select source"); // R9
      if (out_valid && op_e == OP_XOR && ma_e == HM_FULL && mb_e == HM_FULL)
         AST_XOR_FULL: assert ((result ^ src_b) == src_a) else $error("xor full"); // R7
   end

endmodule

// File: tb/sim_simd_hmod_alu.sv
`timescale 1ns/1ps
module sim_simd_hmod_alu;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] src_a, src_b, sel_mask;
   logic [2:0]   op_code;
   logic [2:0]   width_log2;
   logic [1:0]   mod_a, mod_b;
   logic [127:0] result;
   logic         out_valid;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   simd_hmod_alu u0 (
      .src_a      (src_a),
      .src_b      (src_b),
      .sel_mask   (sel_mask),
      .op_code    (op_code),
      .width_log2 (width_log2),
      .mod_a      (mod_a),
      .mod_b      (mod_b),
      .result     (result),
      .out_valid  (out_valid)
   );

   function automatic logic [127:0] half_ref(logic [127:0] x, logic [1:0] m, int hw);
      if (m == 2'd1) return x >> hw;
      if (m == 2'd2) return x & ((128'd1 << hw) - 128'd1);
      return x;
   endfunction

   function automatic logic [127:0] ref_calc(logic [127:0] a, logic [127:0] b,
         logic [127:0] m, logic [2:0] op, logic [2:0] lw, logic [1:0] ma, logic [1:0] mb);
      logic [127:0] res = '0;
      logic [127:0] fmask, fa, fb, fm, r;
      int fw, hw, amt;
      if (lw < 3'd1) return '0;
      fw = 1 << lw;
      hw = fw / 2;
      fmask = (fw == 128) ? '1 : ((128'd1 << fw) - 128'd1);
      for (int f = 0; f < 128 / fw; f++) begin
         fa = half_ref((a >> (f * fw)) & fmask, ma, hw);
         fb = half_ref((b >> (f * fw)) & fmask, mb, hw);
         fm = (m >> (f * fw)) & fmask;
         case (op)
            3'd0: r = fa + fb;
            3'd1: r = fa - fb;
            3'd2: r = (fa < fb) ? fa : fb;
            3'd3: r = fa | fb;
            3'd4: r = fa & fb;
            3'd5: r = fa ^ fb;
            3'd6: begin
               amt = int'(fb[6:0]) & (fw - 1);
               r = (fa << amt) | (fa >> (fw - amt));
            end
            default: r = (fa & fm) | (fb & ~fm);
         endcase
         res |= (r & fmask) << (f * fw);
      end
      return res;
   endfunction

   function automatic string op_tag(logic [2:0] op, logic [2:0] lw);
      if (lw == 3'd0) return "R2";
      case (op)
         3'd0: return "R4";
         3'd1: return "R5";
         3'd2: return "R6";
         3'd6: return "R8";
         3'd7: return "R9";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(logic [127:0] a, logic [127:0] b, logic [127:0] m,
         logic [2:0] op, logic [2:0] lw, logic [1:0] ma, logic [1:0] mb);
      @(negedge clk);
      src_a = a; src_b = b; sel_mask = m;
      op_code = op; width_log2 = lw; mod_a = ma; mod_b = mb;
      #5;
   endtask

   task automatic run_ref(logic [127:0] a, logic [127:0] b, logic [127:0] m,
         logic [2:0] op, logic [2:0] lw, logic [1:0] ma, logic [1:0] mb);
      drive(a, b, m, op, lw, ma, mb);
      chk(op_tag(op, lw), result, ref_calc(a, b, m, op, lw, ma, mb));
      chk(lw == 3'd0 ? "R2" : "R1", {127'd0, out_valid}, {127'd0, lw != 3'd0});
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      src_a = '0; src_b = '0; sel_mask = '0;
      op_code = '0; width_log2 = '0; mod_a = '0; mod_b = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Reset state: code 0 is illegal, so the outputs stay zero (R2)
      drive('1, '1, '1, 3'd0, 3'd0, 2'd0, 2'd0);
      chk("R2", result, '0);
      chk("R2", {127'd0, out_valid}, 128'd0);

      // R1: full 128-bit add wraps to zero
      drive('1, 128'd1, '0, 3'd0, 3'd7, 2'd0, 2'd0);
      chk("R1", result, '0);
      chk("R1", {127'd0, out_valid}, 128'd1);

      // R4: no carry across 8-bit fields
      drive({16{8'hFF}}, {16{8'h01}}, '0, 3'd0, 3'd3, 2'd0, 2'd0);
      chk("R4", result, '0);

      // R3: modifiers on 8-bit fields, OR with zero
      drive({16{8'hA5}}, '0, '0, 3'd3, 3'd3, 2'd1, 2'd0);
      chk("R3", result, {16{8'h0A}});
      drive({16{8'hA5}}, '0, '0, 3'd3, 3'd3, 2'd2, 2'd0);
      chk("R3", result, {16{8'h05}});
      drive({16{8'hA5}}, '0, '0, 3'd3, 3'd3, 2'd3, 2'd0);
      chk("R3", result, {16{8'hA5}});

      // R10: horizontal byte-pair add keeps the carry
      drive({8{16'hFFFF}}, {8{16'hFFFF}}, '0, 3'd0, 3'd4, 2'd1, 2'd2);
      chk("R10", result, {8{16'h01FE}});
      drive({8{16'h7F03}}, {8{16'h7F03}}, '0, 3'd0, 3'd4, 2'd1, 2'd2);
      chk("R10", result, {8{16'h0082}});

      // R11: horizontal min of 16-bit pairs
      drive({4{32'h123400FF}}, {4{32'h123400FF}}, '0, 3'd2, 3'd5, 2'd1, 2'd2);
      chk("R11", result, {4{32'h000000FF}});
      drive({4{32'h0001FFFF}}, {4{32'h0001FFFF}}, '0, 3'd2, 3'd5, 2'd1, 2'd2);
      chk("R11", result, {4{32'h00000001}});

      // R12: rotate left by 8-4 right-justifies 0xF0 to 0x0F
      drive({16{8'hF0}}, {16{8'h04}}, '0, 3'd6, 3'd3, 2'd0, 2'd0);
      chk("R12", result, {16{8'h0F}});
      // R12: rotate left by 16-1 equals rotate right by 1
      drive({8{16'h8003}}, {8{16'h000F}}, '0, 3'd6, 3'd4, 2'd0, 2'd0);
      chk("R12", result, {8{16'hC001}});

      // R8: only low log2(n) amount bits count (0x09 -> 1 at 8 bits)
      drive({16{8'h81}}, {16{8'h09}}, '0, 3'd6, 3'd3, 2'd0, 2'd0);
      chk("R8", result, {16{8'h03}});

      // R9: select by mask
      drive({16{8'hFF}}, '0, {8{16'h0FF0}}, 3'd7, 3'd3, 2'd0, 2'd0);
      chk("R9", result, {8{16'h0FF0}});

      // Sweep of every op, modifier pair and width with random operands
      for (int lw = 0; lw < 8; lw++)
         for (int op = 0; op < 8; op++)
            for (int ma = 0; ma < 4; ma++)
               for (int mb = 0; mb < 4; mb++)
                  for (int k = 0; k < 3; k++)
                     run_ref(rnd128(), rnd128(), rnd128(), 3'(op), 3'(lw), 2'(ma), 2'(mb));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule